// File: doc/BRIEF.md
# Delay-and-Phase Loop Filter for Bang-Bang Clock Recovery

This block is the digital loop filter of a clock recovery loop that steers two actuators at once. Each cycle it takes one early/late vote from a bang-bang phase detector. It keeps a fast delay code for a digitally controlled delay line, and a slower frequency word for a digitally controlled oscillator. The delay code follows every vote directly and is clamped at both ends of its range.

The oscillator word has three parts: a base word, a re-centering term and an anti-false-lock term. The base word comes from the frequency acquisition controller. The re-centering term accumulates the delay code's distance from mid-scale, scaled down by a programmable right shift. This steers the oscillator so that the closed loop pulls the delay line back to its mid-delay point. The anti-false-lock term is a decimated integrator. It sums a programmable power-of-two number of votes and adds each group total to its own accumulator.

While the phase loop is disabled, the filter parks itself. The delay code sits at mid-scale, both accumulators are empty, and the frequency word follows the base word from the acquisition controller.

Top module: `delay_phase_filter`

## Requirements
- R1: The vote is encoded as {early, late}: 10 means +1, 01 means -1, and 00 or 11 mean no update. While enabled, the delay code takes the vote at the next clock edge.
- R2: The delay code saturates. A +1 at 2^DCODE_W-1 or a -1 at 0 leaves it unchanged, and it never wraps.
- R3: While enable is low, the delay code is driven to mid-scale 2^(DCODE_W-1). Both accumulators are cleared and the partial vote group is discarded. One edge later, freq_word equals init_word.
- R4: Reset gives a delay code of mid-scale (128 at default width) and a frequency word of 0.
- R5: On every enabled cycle, the re-centering accumulator adds (delay_code - mid-scale) arithmetically shifted right by ko_shift. Positive offsets therefore raise the frequency word, negative ones lower it, and sign is kept on negative offsets (-3 shifted by 1 gives -2).
- R6: The anti-false-lock path counts only non-zero votes. After each group of 2^h_log2 of them, with h_log2 capped at H_LOG2_MAX, it adds the group's signed sum to its accumulator. A partial group has no effect on the frequency word.
- R7: freq_word is base word plus both accumulators, registered one edge after the accumulators change. It is clamped to the range 0 to 2^FWORD_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Phase loop running; low parks the filter |
| init_word | input | FWORD_W | Base oscillator word from frequency acquisition |
| early | input | 1 | Phase detector early vote |
| late | input | 1 | Phase detector late vote |
| ko_shift | input | SHIFT_W | Right-shift amount for the re-centering gain |
| h_log2 | input | HL_W | log2 of the vote group size of the anti-false-lock path |
| delay_code | output | DCODE_W | Delay line control code |
| freq_word | output | FWORD_W | Oscillator frequency word |

## Verification
A vote reaches delay_code at the first clock edge after it is presented. It reaches the re-centering accumulator one edge later, and freq_word one edge after that. A completed vote group reaches freq_word two edges after its last vote. The bench drives every input on a falling edge and reads delay_code at the next falling edge. Before it reads freq_word it inserts at least two idle vote cycles, so that every check falls after the last register stage has settled. The re-centering slope is measured as the difference between two frequency samples one cycle apart, taken once the delay code has stopped moving.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

   typedef enum logic [1:0] {
      VOTE_NONE = 2'd0,
      VOTE_UP   = 2'd1,
      VOTE_DOWN = 2'd2
   } vote_e;

   function automatic vote_e vote_of(input logic e, input logic l);
      case ({e, l})
         2'b10:   return VOTE_UP;
         2'b01:   return VOTE_DOWN;
         default: return VOTE_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dpf_delay_acc.sv
module dpf_delay_acc
   import dpf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  vote_e         vote,
   output logic [DW-1:0] code
);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
   localparam logic [DW-1:0] TOP = {DW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= MID;
      end else if (!enable) begin
         code <= MID;
      end else begin
         case (vote)
            VOTE_UP:   if (code != TOP)   code <= code + 1'b1;
            VOTE_DOWN: if (code != '0)    code <= code - 1'b1;
            default:   code <= code;
         endcase
      end
   end
endmodule

// File: rtl/dpf_recenter.sv
module dpf_recenter #(
   parameter int DW = 8,
   parameter int AW = 18,
   parameter int SW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [DW-1:0]        code,
   input  logic [SW-1:0]        shift,
   output logic signed [AW-1:0] acc
);
   localparam logic signed [DW:0] MID_X = (DW+1)'(1) << (DW - 1);

   logic signed [DW:0] offset;
   logic signed [DW:0] scaled;
   logic signed [AW:0] inc;
   logic signed [AW:0] sum;

   assign offset = $signed({1'b0, code}) - MID_X;
   assign scaled = offset >>> shift;
   assign inc    = {{(AW - DW){scaled[DW]}}, scaled};
   assign sum    = {acc[AW-1], acc} + inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (!enable) begin
         acc <= '0;
      end else if (sum[AW] != sum[AW-1]) begin
         acc <= sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
      end else begin
         acc <= sum[AW-1:0];
      end
   end
endmodule

// File: rtl/dpf_hdiv.sv
module dpf_hdiv
   import dpf_pkg::*;
#(
   parameter int AW   = 18,
   parameter int HMAX = 4,
   parameter int HL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  vote_e                vote,
   input  logic [HL_W-1:0]      h_log2,
   output logic signed [AW-1:0] acc
);
   localparam int CW = HMAX;
   localparam int SW = HMAX + 2;

   logic [HL_W-1:0]        hl_eff;
   logic [CW-1:0]          limit;
   logic [CW-1:0]          cnt;
   logic signed [SW-1:0]   part;
   logic signed [SW-1:0]   step;
   logic signed [SW-1:0]   total;
   logic signed [AW:0]     sum;

   assign hl_eff = (h_log2 > HL_W'(HMAX)) ? HL_W'(HMAX) : h_log2;
   assign limit  = CW'(((CW+1)'(1) << hl_eff) - (CW+1)'(1));

   always_comb begin
      case (vote)
         VOTE_UP:   step = SW'(1);
         VOTE_DOWN: step = -SW'(1);
         default:   step = '0;
      endcase
   end

   assign total = part + step;
   assign sum   = {{(AW + 1 - SW){total[SW-1]}}, total} + {acc[AW-1], acc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         part <= '0;
         acc  <= '0;
      end else if (!enable) begin
         cnt  <= '0;
         part <= '0;
         acc  <= '0;
      end else if (vote != VOTE_NONE) begin
         if (cnt == limit) begin
            cnt  <= '0;
            part <= '0;
            if (sum[AW] != sum[AW-1])
               acc <= sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
            else
               acc <= sum[AW-1:0];
         end else begin
            cnt  <= cnt + 1'b1;
            part <= total;
         end
      end
   end
endmodule

// File: rtl/delay_phase_filter.sv
module delay_phase_filter
   import dpf_pkg::*;
#(
   parameter int DCODE_W    = 8,
   parameter int FWORD_W    = 16,
   parameter int SHIFT_W    = 4,
   parameter int H_LOG2_MAX = 4,
   parameter bit HDIV_EN    = 1'b1,
   parameter int HL_W       = $clog2(H_LOG2_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [FWORD_W-1:0] init_word,
   input  logic               early,
   input  logic               late,
   input  logic [SHIFT_W-1:0] ko_shift,
   input  logic [HL_W-1:0]    h_log2,
   output logic [DCODE_W-1:0] delay_code,
   output logic [FWORD_W-1:0] freq_word
);
   localparam int ACC_W = FWORD_W + 2;
   localparam int TW    = ACC_W + 2;

   if (DCODE_W < 2) begin : g_bad_dw
      $error("DCODE_W must be at least 2");
   end
   if (FWORD_W < DCODE_W) begin : g_bad_fw
      $error("FWORD_W must be at least DCODE_W");
   end
   if (H_LOG2_MAX < 1 || H_LOG2_MAX > FWORD_W) begin : g_bad_h
      $error("H_LOG2_MAX out of range");
   end

   vote_e                    vote;
   logic signed [ACC_W-1:0]  acc_o;
   logic signed [ACC_W-1:0]  acc_h;
   logic [FWORD_W-1:0]       base_q;
   logic signed [TW-1:0]     total;

   assign vote = vote_of(early, late);

   dpf_delay_acc #(.DW(DCODE_W)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .vote   (vote),
      .code   (delay_code)
   );

   dpf_recenter #(.DW(DCODE_W), .AW(ACC_W), .SW(SHIFT_W)) u_recenter (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .code   (delay_code),
      .shift  (ko_shift),
      .acc    (acc_o)
   );

   if (HDIV_EN) begin : g_hdiv
      dpf_hdiv #(.AW(ACC_W), .HMAX(H_LOG2_MAX), .HL_W(HL_W)) u_hdiv (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (enable),
         .vote   (vote),
         .h_log2 (h_log2),
         .acc    (acc_h)
      );
   end else begin : g_no_hdiv
      assign acc_h = '0;
   end

   assign total = $signed({{(TW - FWORD_W){1'b0}}, base_q})
                + $signed({{(TW - ACC_W){acc_o[ACC_W-1]}}, acc_o})
                + $signed({{(TW - ACC_W){acc_h[ACC_W-1]}}, acc_h});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         freq_word <= '0;
      end else if (!enable) begin
         base_q    <= init_word;
         freq_word <= init_word;
      end else if (total[TW-1]) begin
         freq_word <= '0;
      end else if (|total[TW-2:FWORD_W]) begin
         freq_word <= {FWORD_W{1'b1}};
      end else begin
         freq_word <= total[FWORD_W-1:0];
      end
   end
endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
   parameter int DCODE_W = 8,
   parameter int FWORD_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic               early,
   input logic               late,
   input logic [FWORD_W-1:0] init_word,
   input logic [DCODE_W-1:0] delay_code,
   input logic [FWORD_W-1:0] freq_word
);
   localparam logic [DCODE_W-1:0] MID = DCODE_W'(1) << (DCODE_W - 1);
   localparam logic [DCODE_W-1:0] TOP = {DCODE_W{1'b1}};

   assert_idle_vote_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (early == late)) |=> $stable(delay_code));

   assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && early && !late && delay_code != TOP)
         |=> delay_code == DCODE_W'($past(delay_code) + 1'b1));

   assert_hold_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && early && !late && delay_code == TOP) |=> delay_code == TOP);

   assert_hold_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !early && late && delay_code == '0) |=> delay_code == '0);

   assert_park_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> delay_code == MID);

   assert_park_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> freq_word == $past(init_word));
endmodule

bind delay_phase_filter dpf_checker #(.DCODE_W(DCODE_W), .FWORD_W(FWORD_W)) u_dpf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .early      (early),
   .late       (late),
   .init_word  (init_word),
   .delay_code (delay_code),
   .freq_word  (freq_word)
);

// File: tb/delay_phase_filter_bench.sv
`timescale 1ns/1ps
module delay_phase_filter_bench;
   localparam int DW = 8;
   localparam int FW = 16;
   localparam int MIDV = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [FW-1:0] init_word = '0;
   logic          early = 1'b0;
   logic          late = 1'b0;
   logic [3:0]    ko_shift = 4'd15;
   logic [2:0]    h_log2 = 3'd4;
   logic [DW-1:0] delay_code;
   logic [FW-1:0] freq_word;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   delay_phase_filter u_delay_phase_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .init_word  (init_word),
      .early      (early),
      .late       (late),
      .ko_shift   (ko_shift),
      .h_log2     (h_log2),
      .delay_code (delay_code),
      .freq_word  (freq_word)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input logic e, input logic l);
      early = e;
      late  = l;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   task automatic restart(input int init, input int sh, input int hl);
      enable    = 1'b0;
      init_word = FW'(init);
      ko_shift  = 4'(sh);
      h_log2    = 3'(hl);
      idle(2);
      enable = 1'b1;
   endtask

   task automatic t_reset;
      check("R4", "delay code at reset", int'(delay_code), MIDV);
      check("R4", "freq word at reset", int'(freq_word), 0);
   endtask

   task automatic t_parked;
      enable    = 1'b0;
      init_word = 16'd1000;
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      check("R3", "delay ignores votes while parked", int'(delay_code), MIDV);
      check("R3", "freq follows init while parked", int'(freq_word), 1000);
   endtask

   task automatic t_votes;
      restart(2000, 15, 4);
      step(1'b1, 1'b0);
      check("R1", "early vote 10", int'(delay_code), 129);
      step(1'b1, 1'b0);
      check("R1", "second early vote", int'(delay_code), 130);
      step(1'b0, 1'b1);
      check("R1", "late vote 01", int'(delay_code), 129);
      step(1'b0, 1'b0);
      check("R1", "vote 00 no update", int'(delay_code), 129);
      step(1'b1, 1'b1);
      check("R1", "vote 11 no update", int'(delay_code), 129);
      idle(2);
      check("R7", "freq equals base with zero terms", int'(freq_word), 2000);
   endtask

   task automatic t_saturate;
      restart(2000, 15, 4);
      for (int i = 0; i < 130; i++) step(1'b1, 1'b0);
      check("R2", "delay clamps at top", int'(delay_code), 255);
      step(1'b1, 1'b0);
      check("R2", "delay holds at top", int'(delay_code), 255);
      step(1'b0, 1'b1);
      check("R2", "delay leaves top", int'(delay_code), 254);
      restart(2000, 15, 4);
      for (int i = 0; i < 130; i++) step(1'b0, 1'b1);
      check("R2", "delay clamps at floor", int'(delay_code), 0);
      step(1'b0, 1'b1);
      check("R2", "delay holds at floor", int'(delay_code), 0);
      step(1'b1, 1'b0);
      check("R2", "delay leaves floor", int'(delay_code), 1);
   endtask

   task automatic slope(input int sh, input logic up, input int exp, input string what);
      int f1;
      restart(1000, sh, 4);
      for (int i = 0; i < 3; i++) step(up, ~up);
      idle(3);
      f1 = int'(freq_word);
      idle(1);
      check("R5", what, int'(freq_word) - f1, exp);
   endtask

   task automatic t_recenter;
      slope(0, 1'b1, 3, "slope +3 shift 0");
      slope(1, 1'b1, 1, "slope +3 shift 1");
      slope(1, 1'b0, -2, "slope -3 shift 1 arithmetic");
   endtask

   task automatic t_hdiv;
      restart(5000, 15, 2);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      idle(2);
      check("R6", "partial group has no effect", int'(freq_word), 5000);
      step(1'b0, 1'b1);
      idle(2);
      check("R6", "group E,E,E,L adds +2", int'(freq_word), 5002);
      step(1'b1, 1'b0);
      idle(1);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      idle(2);
      check("R6", "idle cycles not counted", int'(freq_word), 5002);
      step(1'b0, 1'b1);
      idle(2);
      check("R6", "group E,L,L,L adds -2", int'(freq_word), 5000);
   endtask

   task automatic t_clamp;
      restart(65535, 0, 4);
      step(1'b1, 1'b0);
      idle(5);
      check("R7", "freq clamps at top", int'(freq_word), 65535);
      restart(0, 0, 4);
      step(1'b0, 1'b1);
      idle(5);
      check("R7", "freq clamps at zero", int'(freq_word), 0);
   endtask

   task automatic t_reload;
      enable    = 1'b0;
      init_word = 16'd777;
      step(1'b0, 1'b1);
      check("R3", "delay parked at mid", int'(delay_code), MIDV);
      check("R3", "freq loads new init", int'(freq_word), 777);
      enable = 1'b1;
      idle(3);
      check("R3", "accumulators cleared on park", int'(freq_word), 777);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_parked();
      t_votes();
      t_saturate();
      t_recenter();
      t_hdiv();
      t_clamp();
      t_reload();
      finish_run();
   end
endmodule